// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 16-bit successive-approximation converter. The converter is built around two mirrored charge-redistribution capacitor arrays, one for each side of a differential input. While idle, the block holds the arrays in the sampling configuration. A high level on the convert-start input begins a conversion. The block first opens the comparator-side ground switches, then moves every array element off its analog input onto ground. After that it runs a binary search of one trial per bit, from the most significant bit down to the least significant bit. In each trial the element under test is switched from ground to the reference.

A single comparator output is read at the end of each trial. When the last bit is resolved, the block returns the arrays to sampling. In the same cycle it loads the result into the output code register, drops its busy flag and pulses a done strobe. The result belongs to the sample taken when that conversion began, so there is no pipeline latency. The block runs on its own conversion clock, and no serial clock takes part in a conversion. The reset input is asynchronous and active-low. Its release is synchronised to the clock inside the block.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `busy_o` and `done_o` are 0 and `code_o` is 0. The switches are in the sampling state: both ground switches closed (1), every element connected to its input (`elem_in_*` all ones), and every REF select 0.
- R2: When `cnv_i` is sampled high at a rising edge while `busy_o` is 0, a conversion starts and `busy_o` is 1 in the following cycle.
- R3: In the first conversion cycle, both ground switches are open (0) and all elements are still on their inputs. In the second cycle, all elements are off their inputs (`elem_in_*` all zeros) and both REF selects are all zeros, meaning every element is at ground. An element never leaves its input while a ground switch is closed.
- R4: Each bit takes two cycles, starting at bit 15 and ending at bit 0. For both cycles of a trial, `elem_ref_p_o` equals the bits already resolved plus a 1 at the bit under test. `elem_ref_n_o` is the bitwise complement of `elem_ref_p_o`.
- R5: At the end of a trial, the bit under test is kept at 1 if `cmp_i` is 0 (trial code not above the input) and cleared if `cmp_i` is 1. With an ideal comparator, the result therefore equals the sampled input value. A comparator stuck at 1 gives 0x0000, and one stuck at 0 gives 0xFFFF.
- R6: `busy_o` stays high for exactly 34 cycles: two setup cycles plus two per bit.
- R7: In the cycle in which `busy_o` falls, `code_o` takes the new result and `done_o` is 1 for that single cycle. At other times `code_o` holds its value.
- R8: A `cnv_i` high while `busy_o` is 1 has no effect. The conversion keeps its length and its result, and no new conversion starts after it ends.
- R9: When a conversion ends, the switches return to the sampling state of R1.
- R10: Asserting reset during a conversion immediately returns the block to the state of R1 and clears all trial bits. The next conversion after release converts correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| cnv_i | input | 1 | Convert-start level |
| cmp_i | input | 1 | Comparator output: 1 when the trial code is above the held input |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle strobe when a result is loaded |
| code_o | output | 16 | Last conversion result |
| gnd_sw_p_o | output | 1 | Positive array comparator-side ground switch (1 = closed) |
| gnd_sw_n_o | output | 1 | Negative array comparator-side ground switch (1 = closed) |
| elem_in_p_o | output | 16 | Positive array elements connected to the input (1 = connected) |
| elem_in_n_o | output | 16 | Negative array elements connected to the input (1 = connected) |
| elem_ref_p_o | output | 16 | Positive array element at REF (1) or GND (0) when off the input |
| elem_ref_n_o | output | 16 | Negative array element at REF (1) or GND (0) when off the input |

## Verification
A wrong phase state shows at the switch ports in the very next cycle. A skipped or repeated setup phase breaks the ground-switch-then-detach order within two cycles. A wrong bit index or decision shows as a REF pattern that differs from the expected partial code within two cycles of the fault. A broken counter or enable shows only at the end of a conversion: as a busy length other than 34, a missing or doubled done pulse, or a wrong code. The bench therefore traces the REF pattern trial by trial as well as checking the final result.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    PH_ACQ    = 3'd0,
    PH_OPEN   = 3'd1,
    PH_DETACH = 3'd2,
    PH_SET    = 3'd3,
    PH_DECIDE = 3'd4
  } phase_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_seq_pkg::*;
#(
  parameter int N_BITS = 16,
  localparam int IDX_W = $clog2(N_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             clr_o,
  output logic             set_en_o,
  output logic [IDX_W-1:0] set_idx_o,
  output logic             decide_o,
  output logic             finish_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(N_BITS - 1);

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  // next-state logic
  always_comb begin
    phase_d   = phase_q;
    idx_d     = idx_q;
    idx_en    = 1'b0;
    clr_o     = 1'b0;
    set_en_o  = 1'b0;
    set_idx_o = idx_q;
    decide_o  = 1'b0;
    finish_o  = 1'b0;
    unique case (phase_q)
      PH_ACQ: begin
        if (cnv_i) begin
          phase_d = PH_OPEN;
          clr_o   = 1'b1;
        end
      end
      PH_OPEN:   phase_d = PH_DETACH;
      PH_DETACH: begin
        phase_d   = PH_SET;
        idx_d     = IDX_TOP;
        idx_en    = 1'b1;
        set_en_o  = 1'b1;
        set_idx_o = IDX_TOP;
      end
      PH_SET:    phase_d = PH_DECIDE;
      PH_DECIDE: begin
        decide_o = 1'b1;
        if (idx_q == '0) begin
          phase_d  = PH_ACQ;
          finish_o = 1'b1;
        end else begin
          phase_d   = PH_SET;
          idx_d     = idx_q - 1'b1;
          idx_en    = 1'b1;
          set_en_o  = 1'b1;
          set_idx_o = idx_q - 1'b1;
        end
      end
      default:   phase_d = PH_ACQ;
    endcase
    busy_d = (phase_d != PH_ACQ);
    done_d = finish_o;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ACQ;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (idx_en) idx_q <= idx_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int N_BITS = 16,
  localparam int IDX_W = $clog2(N_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              set_en_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  input  logic              decide_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              cmp_i,
  input  logic              finish_i,
  output logic [N_BITS-1:0] trial_o,
  output logic [N_BITS-1:0] code_o
);
  logic [N_BITS-1:0] trial_q, trial_d;
  logic [N_BITS-1:0] code_q, code_d;
  logic              trial_en, code_en;

  always_comb begin
    trial_d = trial_q;
    if (clr_i)              trial_d = '0;
    if (decide_i && cmp_i)  trial_d[idx_i] = 1'b0;
    if (set_en_i)           trial_d[set_idx_i] = 1'b1;
    trial_en = clr_i | decide_i | set_en_i;
    code_en  = finish_i;
    code_d   = trial_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      code_q  <= '0;
    end else begin
      if (trial_en) trial_q <= trial_d;
      if (code_en)  code_q  <= code_d;
    end
  end

  assign trial_o = trial_q;
  assign code_o  = code_q;
endmodule

// File: rtl/sar_switch_drv.sv
module sar_switch_drv
  import sar_seq_pkg::*;
#(
  parameter int N_BITS = 16
) (
  input  phase_e            phase_i,
  input  logic [N_BITS-1:0] trial_i,
  output logic              gnd_sw_p_o,
  output logic              gnd_sw_n_o,
  output logic [N_BITS-1:0] elem_in_p_o,
  output logic [N_BITS-1:0] elem_in_n_o,
  output logic [N_BITS-1:0] elem_ref_p_o,
  output logic [N_BITS-1:0] elem_ref_n_o
);
  logic              gnd_cl;
  logic              on_in;
  logic              trial_ph;

  always_comb begin
    gnd_cl   = (phase_i == PH_ACQ);
    on_in    = (phase_i == PH_ACQ) || (phase_i == PH_OPEN);
    trial_ph = (phase_i == PH_SET) || (phase_i == PH_DECIDE);
  end

  assign gnd_sw_p_o = gnd_cl;
  assign gnd_sw_n_o = gnd_cl;

  for (genvar b = 0; b < N_BITS; b++) begin : g_elem
    assign elem_in_p_o[b]  = on_in;
    assign elem_in_n_o[b]  = on_in;
    assign elem_ref_p_o[b] = trial_ph &  trial_i[b];
    assign elem_ref_n_o[b] = trial_ph & ~trial_i[b];
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int N_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [N_BITS-1:0] code_o,
  output logic              gnd_sw_p_o,
  output logic              gnd_sw_n_o,
  output logic [N_BITS-1:0] elem_in_p_o,
  output logic [N_BITS-1:0] elem_in_n_o,
  output logic [N_BITS-1:0] elem_ref_p_o,
  output logic [N_BITS-1:0] elem_ref_n_o
);
  localparam int IDX_W = $clog2(N_BITS);

  logic              rst_sync_n;
  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic              clr, set_en, decide, finish;
  logic [IDX_W-1:0]  set_idx;
  logic [N_BITS-1:0] trial;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sar_phase_ctrl #(.N_BITS(N_BITS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cnv_i     (cnv_i),
    .phase_o   (phase),
    .idx_o     (idx),
    .clr_o     (clr),
    .set_en_o  (set_en),
    .set_idx_o (set_idx),
    .decide_o  (decide),
    .finish_o  (finish),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  sar_trial_reg #(.N_BITS(N_BITS)) u_trial (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (clr),
    .set_en_i  (set_en),
    .set_idx_i (set_idx),
    .decide_i  (decide),
    .idx_i     (idx),
    .cmp_i     (cmp_i),
    .finish_i  (finish),
    .trial_o   (trial),
    .code_o    (code_o)
  );

  sar_switch_drv #(.N_BITS(N_BITS)) u_sw (
    .phase_i      (phase),
    .trial_i      (trial),
    .gnd_sw_p_o   (gnd_sw_p_o),
    .gnd_sw_n_o   (gnd_sw_n_o),
    .elem_in_p_o  (elem_in_p_o),
    .elem_in_n_o  (elem_in_n_o),
    .elem_ref_p_o (elem_ref_p_o),
    .elem_ref_n_o (elem_ref_n_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
  import sar_seq_pkg::*;
#(
  parameter int N_BITS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnv_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [N_BITS-1:0] code_o,
  input logic              gnd_sw_p_o,
  input logic              gnd_sw_n_o,
  input logic [N_BITS-1:0] elem_in_p_o,
  input logic [N_BITS-1:0] elem_in_n_o,
  input logic [N_BITS-1:0] elem_ref_p_o,
  input logic [N_BITS-1:0] elem_ref_n_o,
  input phase_e            phase
);
  localparam int TOTAL = 2 + 2 * N_BITS;
  localparam int CNT_W = $clog2(TOTAL + 2);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cnv_i) |=> busy_o);

  p_gnd_before_detach_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnd_sw_p_o || gnd_sw_n_o) |-> (&elem_in_p_o && &elem_in_n_o));

  p_open_then_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(elem_in_p_o[0]) |-> ($past(!gnd_sw_p_o) && $past(!gnd_sw_n_o)));

  p_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SET || phase == PH_DECIDE) |-> (elem_ref_n_o == ~elem_ref_p_o));

  p_trial_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SET) |=> $stable(elem_ref_p_o));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_cnt == CNT_W'(TOTAL)));

  p_done_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o));

  p_sample_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (gnd_sw_p_o && gnd_sw_n_o && elem_ref_p_o == '0 && elem_ref_n_o == '0));
endmodule

bind sar_seq sar_seq_chk #(.N_BITS(N_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cnv_i        (cnv_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .code_o       (code_o),
  .gnd_sw_p_o   (gnd_sw_p_o),
  .gnd_sw_n_o   (gnd_sw_n_o),
  .elem_in_p_o  (elem_in_p_o),
  .elem_in_n_o  (elem_in_n_o),
  .elem_ref_p_o (elem_ref_p_o),
  .elem_ref_n_o (elem_ref_n_o),
  .phase        (phase)
);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnv = 1'b0;
  logic         cmp;
  logic         busy, done;
  logic [N-1:0] code;
  logic         gnd_p, gnd_n;
  logic [N-1:0] in_p, in_n, ref_p, ref_n;

  logic [N-1:0] vin = '0;
  logic [N-1:0] held = '0;
  int           cmp_mode = 0;   // 0 ideal, 1 stuck high, 2 stuck low
  int           n_checks = 0;
  int           n_fail = 0;

  always #4 clk = ~clk;

  assign cmp = (cmp_mode == 1) ? 1'b1 : (cmp_mode == 2) ? 1'b0 : (ref_p > held);

  sar_seq u0 (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .cmp_i(cmp),
    .busy_o(busy), .done_o(done), .code_o(code),
    .gnd_sw_p_o(gnd_p), .gnd_sw_n_o(gnd_n),
    .elem_in_p_o(in_p), .elem_in_n_o(in_n),
    .elem_ref_p_o(ref_p), .elem_ref_n_o(ref_n)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_sampling(input string req);
    check(req, {busy, gnd_p, gnd_n}, 3'b011);
    check(req, {in_p, in_n}, {2*N{1'b1}});
    check(req, {ref_p, ref_n}, '0);
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  // pulse convert for one cycle; on return the first busy cycle is visible
  task automatic start_conv(input logic [N-1:0] value);
    @(negedge clk);
    vin  = value;
    held = value;
    cnv  = 1'b1;
    @(negedge clk);
    cnv = 1'b0;
    #1;
  endtask

  // counts busy cycles, returns at the cycle busy falls
  task automatic finish_conv(output int cycles);
    cycles = busy ? 1 : 0;
    for (int k = 0; k < 100 && busy; k++) begin
      tick();
      if (busy) cycles++;
    end
  endtask

  function automatic logic [N-1:0] expect_code(input logic [N-1:0] v, input int mode);
    if (mode == 1) return '0;
    if (mode == 2) return '1;
    return v;
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) tick();
    check_sampling("R1 during reset");
    check("R1 done/code", {done, code}, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) tick();
    check_sampling("R1 after release");
    check("R1 done/code", {done, code}, '0);
  endtask

  task automatic t_trace(input logic [N-1:0] value);
    logic [N-1:0] acc;
    logic [N-1:0] tr;
    int cyc;
    acc = '0;
    cmp_mode = 0;
    start_conv(value);
    check("R2 busy after start", busy, 1'b1);
    check("R3 open phase", {gnd_p, gnd_n, in_p, in_n}, {2'b00, {2*N{1'b1}}});
    tick();
    check("R3 detach phase", {gnd_p, gnd_n, in_p, in_n, ref_p, ref_n}, '0);
    for (int b = N - 1; b >= 0; b--) begin
      tr = acc | (N'(1) << b);
      for (int h = 0; h < 2; h++) begin
        tick();
        n_checks++;
        if (ref_p !== tr || ref_n !== ~tr || busy !== 1'b1) begin
          n_fail++;
          $display("FAIL R4 bit %0d half %0d actual=%h/%h expected=%h/%h",
                   b, h, ref_p, ref_n, tr, ~tr);
        end
      end
      if (!(tr > value)) acc = tr;
    end
    tick();
    check("R7 done at busy fall", {busy, done}, 2'b01);
    check("R5 traced code", code, acc);
    check("R5 code equals input", code, value);
    check_sampling("R9 back to sampling");
    tick();
    check("R7 done single", done, 1'b0);
    cyc = 0;
  endtask

  task automatic t_convert(input logic [N-1:0] value, input int mode, input string tag);
    int cyc;
    cmp_mode = mode;
    start_conv(value);
    finish_conv(cyc);
    check({tag, " R6 busy cycles"}, cyc, 34);
    check({tag, " R7 done"}, done, 1'b1);
    check({tag, " R5 code"}, code, expect_code(value, mode));
    tick();
    check({tag, " R7 done single"}, done, 1'b0);
    cmp_mode = 0;
  endtask

  task automatic t_ignore_busy;
    int cyc;
    start_conv(16'h5A3C);
    repeat (5) tick();
    @(negedge clk); cnv = 1'b1;
    vin = 16'h0F0F;
    @(negedge clk); cnv = 1'b0;
    #1;
    finish_conv(cyc);
    check("R8 busy cycles", cyc + 7, 34);
    check("R8 code kept", code, 16'h5A3C);
    tick();
    check("R8 no restart", busy, 1'b0);
    check_sampling("R8 sampling after end");
  endtask

  task automatic t_hold;
    logic [N-1:0] was;
    was = code;
    vin = ~was;
    repeat (6) tick();
    check("R7 code hold", code, was);
  endtask

  task automatic t_reset_mid;
    int cyc;
    start_conv(16'hFFFF);
    repeat (10) tick();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_sampling("R10 async reset");
    check("R10 code cleared", code, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) tick();
    check_sampling("R10 after release");
    start_conv(16'h0001);
    tick(); tick(); tick();
    check("R10 first trial clean", ref_p, 16'h8000);
    finish_conv(cyc);
    check("R10 code after reset", code, 16'h0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_trace(16'hA5C3);
    t_trace(16'h0000);
    t_trace(16'hFFFF);
    t_convert(16'h8000, 0, "mid");
    t_convert(16'h7FFF, 0, "below-mid");
    t_convert(16'h1234, 1, "stuck-high");
    t_convert(16'h1234, 2, "stuck-low");
    t_hold();
    t_ignore_busy();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule